// File: doc/BRIEF.md
# Sync Frequency and Polarity Monitor

This block watches the horizontal and vertical sync inputs of a display signal and measures them against a free-running oscillator clock. It reports a line-rate count, a frame-rate count, one saturation indicator for each, and the detected polarity of each input. It also keeps four sticky event flags with individual enables. Together these drive an active-low interrupt, so firmware can react when a new video mode appears or a cable is pulled.

Both inputs are resynchronised and cleaned of single-clock spikes before any edge is detected. The line measurement is taken over a power-of-two group of lines. The frame measurement runs from one vsync leading edge to the next. Each count goes through its own prescaler, and only its upper bits are published. When vsync is running, the line value is refreshed once per frame. When vsync has stopped, the line value follows each finished line group.

Top module: `sync_monitor`

## Requirements
- R1: The H value equals the upper H_OUT_W bits of floor(T / H_DIV). T is the number of oscillator clocks spanned by 2^H_LINES_LOG2 consecutive hsync periods, measured between rising edges.
- R2: While vOvf is 0, hValue changes only in response to a vsync rising edge, and then takes the most recently finished line-group result. While vOvf is 1, hValue takes each line-group result as soon as the group finishes.
- R3: At every vsync rising edge, vValue takes the upper V_OUT_W bits of floor(P / V_DIV), where P is the vsync period in clocks. Between vsync edges vValue holds.
- R4: hOvf (vOvf) goes to 1 when the H (V) counter saturates at all ones. It returns to 0 once a measurement finishes without saturating.
- R5: flags[1] (H frequency) sets when hValue takes a different value or when hOvf rises. flags[0] (V frequency) sets when vValue takes a different value or when vOvf rises.
- R6: At each rising edge, a polarity bit is updated: 0 (negative) when the preceding high time was longer than the low time, and 1 (positive) otherwise, which includes equal times.
- R7: flags[3] sets when hPolPos changes. flags[2] sets when vPolPos changes.
- R8: An input pulse lasting one oscillator clock has no effect on counts, polarity or flags.
- R9: When flagWrEn is 1, each flag whose flagWrData bit is 0 clears, and each flag whose bit is 1 is kept. With no write, a flag never clears. A new event wins over a clear in the same cycle.
- R10: intN is 0 exactly when some flag is 1 and its intEn bit (same position) is 1. Otherwise intN is 1.
- R11: After reset, the values are 0, the overflow bits are 0, both polarity bits are 1, the flags are 0 and intN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hSyncIn | input | 1 | Horizontal sync, asynchronous |
| vSyncIn | input | 1 | Vertical sync, asynchronous |
| flagWrEn | input | 1 | Flag write strobe |
| flagWrData | input | 4 | Write data: 0 clears the flag, 1 keeps it |
| intEn | input | 4 | Per-flag interrupt enables |
| hValue | output | H_OUT_W | Line-rate count |
| vValue | output | V_OUT_W | Frame-rate count |
| hOvf | output | 1 | H counter saturated |
| vOvf | output | 1 | V counter saturated |
| hPolPos | output | 1 | 1 = hsync positive |
| vPolPos | output | 1 | 1 = vsync positive |
| flags | output | 4 | [3] H polarity, [2] V polarity, [1] H frequency, [0] V frequency |
| intN | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with an 8-bit H counter that keeps 5 bits, 4-line groups, H_DIV=2, a 10-bit V counter that keeps 6 bits, V_DIV=2 and 12-bit pulse counters. With these widths, line periods of 12 to 30 clocks give distinct H values. Saturation of either counter comes within a few thousand clocks, so both overflow paths and the vsync-absent latch rule can be exercised in a short run. A one-clock spike is injected into the low phase of hsync to show that the filter leaves the counts, the polarity and the flags untouched.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int NFLAG = 4;
  // order fixes flag bit positions: [3] hPol, [2] vPol, [1] hFreq, [0] vFreq
  typedef struct packed {
    logic hPolEv;
    logic vPolEv;
    logic hFreqEv;
    logic vFreqEv;
  } smonEvt_t;
endpackage

// File: rtl/sync_inpath.sv
module sync_inpath #(
  parameter int POL_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic rise,
  output logic polPos,
  output logic polChg
);
  logic [2:0] syncQ;
  logic filt, filtD, fall, newPos;
  logic [POL_W-1:0] segCnt, highLen;

  assign rise   = filt & ~filtD;
  assign fall   = ~filt & filtD;
  assign newPos = !(highLen > segCnt);
  assign polChg = rise && (newPos != polPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      filt    <= 1'b0;
      filtD   <= 1'b0;
      segCnt  <= '0;
      highLen <= '0;
      polPos  <= 1'b1;
    end else begin
      syncQ <= {syncQ[1:0], rawIn};
      if (syncQ[2] == syncQ[1]) filt <= syncQ[1];
      filtD <= filt;
      if (rise || fall) segCnt <= POL_W'(1);
      else if (!(&segCnt)) segCnt <= segCnt + 1'b1;
      if (fall) highLen <= segCnt;
      if (rise) polPos <= newPos;
    end
  end
endmodule

// File: rtl/sync_period.sv
module sync_period #(
  parameter int W   = 15,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         capture,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] CNT_START = W'(DIV == 1 ? 1 : 0);
  logic tick, sat;
  assign sat = &count;

  generate
    if (DIV > 1) begin : g_pre
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] preQ;
      assign tick = (preQ == PW'(DIV - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        preQ <= '0;
        else if (capture) preQ <= PW'(1);
        else if (tick)    preQ <= '0;
        else              preQ <= preQ + 1'b1;
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (capture)          count <= CNT_START;
      else if (tick && !sat) count <= count + 1'b1;
      if (capture)  ovf <= sat;
      else if (sat) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_mon_dp.sv
module sync_mon_dp
  import smon_pkg::*;
#(
  parameter int H_CNT_W      = 15,
  parameter int H_OUT_W      = 11,
  parameter int H_DIV        = 2,
  parameter int H_LINES_LOG2 = 6,
  parameter int V_CNT_W      = 14,
  parameter int V_OUT_W      = 9,
  parameter int V_DIV        = 16,
  parameter int POL_W        = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hSyncIn,
  input  logic               vSyncIn,
  output logic [H_OUT_W-1:0] hValue,
  output logic [V_OUT_W-1:0] vValue,
  output logic               hOvf,
  output logic               vOvf,
  output logic               hPolPos,
  output logic               vPolPos,
  output smonEvt_t           evt
);
  logic [1:0] rawIn, riseS, polS, polChgS;
  logic [H_LINES_LOG2-1:0] lineCnt;
  logic [H_CNT_W-1:0] hCount;
  logic [V_CNT_W-1:0] vCount;
  logic [H_OUT_W-1:0] hHeld, hNext, hTop;
  logic [V_OUT_W-1:0] vTop;
  logic hGroupDone, hLoad, hOvfD, vOvfD;

  assign rawIn = {vSyncIn, hSyncIn};

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_in
      sync_inpath #(.POL_W(POL_W)) u_in (
        .clk(clk), .rstN(rstN), .rawIn(rawIn[gi]),
        .rise(riseS[gi]), .polPos(polS[gi]), .polChg(polChgS[gi])
      );
    end
  endgenerate

  assign hGroupDone = riseS[0] && (&lineCnt);

  sync_period #(.W(H_CNT_W), .DIV(H_DIV)) u_hPer (
    .clk(clk), .rstN(rstN), .capture(hGroupDone), .count(hCount), .ovf(hOvf)
  );
  sync_period #(.W(V_CNT_W), .DIV(V_DIV)) u_vPer (
    .clk(clk), .rstN(rstN), .capture(riseS[1]), .count(vCount), .ovf(vOvf)
  );

  assign hTop = hCount[H_CNT_W-1 -: H_OUT_W];
  assign vTop = vCount[V_CNT_W-1 -: V_OUT_W];
  assign hPolPos = polS[0];
  assign vPolPos = polS[1];

  always_comb begin
    hLoad = 1'b0;
    hNext = hValue;
    if (!vOvf) begin
      if (riseS[1]) begin
        hLoad = 1'b1;
        hNext = hHeld;
      end
    end else if (hGroupDone) begin
      hLoad = 1'b1;
      hNext = hTop;
    end
  end

  always_comb begin
    evt.hPolEv  = polChgS[0];
    evt.vPolEv  = polChgS[1];
    evt.hFreqEv = (hLoad && (hNext != hValue)) || (hOvf && !hOvfD);
    evt.vFreqEv = (riseS[1] && (vTop != vValue)) || (vOvf && !vOvfD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
      hHeld   <= '0;
      hValue  <= '0;
      vValue  <= '0;
      hOvfD   <= 1'b0;
      vOvfD   <= 1'b0;
    end else begin
      if (riseS[0]) lineCnt <= lineCnt + 1'b1;
      if (hGroupDone) hHeld <= hTop;
      if (hLoad) hValue <= hNext;
      if (riseS[1]) vValue <= vTop;
      hOvfD <= hOvf;
      vOvfD <= vOvf;
    end
  end
endmodule

// File: rtl/sync_mon_ctrl.sv
module sync_mon_ctrl
  import smon_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  smonEvt_t         evt,
  input  logic             flagWrEn,
  input  logic [NFLAG-1:0] flagWrData,
  input  logic [NFLAG-1:0] intEn,
  output logic [NFLAG-1:0] flags,
  output logic             intN
);
  logic [NFLAG-1:0] setVec, clrVec;
  assign setVec = evt;
  assign clrVec = flagWrEn ? ~flagWrData : '0;
  assign intN   = ~|(flags & intEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrVec) | setVec;
  end
endmodule

// File: rtl/sync_monitor.sv
module sync_monitor
  import smon_pkg::*;
#(
  parameter int H_CNT_W      = 15,
  parameter int H_OUT_W      = 11,
  parameter int H_DIV        = 2,
  parameter int H_LINES_LOG2 = 6,
  parameter int V_CNT_W      = 14,
  parameter int V_OUT_W      = 9,
  parameter int V_DIV        = 16,
  parameter int POL_W        = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hSyncIn,
  input  logic               vSyncIn,
  input  logic               flagWrEn,
  input  logic [3:0]         flagWrData,
  input  logic [3:0]         intEn,
  output logic [H_OUT_W-1:0] hValue,
  output logic [V_OUT_W-1:0] vValue,
  output logic               hOvf,
  output logic               vOvf,
  output logic               hPolPos,
  output logic               vPolPos,
  output logic [3:0]         flags,
  output logic               intN
);
  smonEvt_t evt;

  sync_mon_dp #(
    .H_CNT_W(H_CNT_W), .H_OUT_W(H_OUT_W), .H_DIV(H_DIV), .H_LINES_LOG2(H_LINES_LOG2),
    .V_CNT_W(V_CNT_W), .V_OUT_W(V_OUT_W), .V_DIV(V_DIV), .POL_W(POL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .hValue(hValue), .vValue(vValue), .hOvf(hOvf), .vOvf(vOvf),
    .hPolPos(hPolPos), .vPolPos(vPolPos), .evt(evt)
  );

  sync_mon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .intEn(intEn), .flags(flags), .intN(intN)
  );
endmodule

// File: rtl/sync_monitor_chk.sv
module sync_monitor_chk #(
  parameter int H_OUT_W = 11,
  parameter int V_OUT_W = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic [H_OUT_W-1:0] hValue,
  input logic [V_OUT_W-1:0] vValue,
  input logic               hOvf,
  input logic               hPolPos,
  input logic               flagWrEn,
  input logic [3:0]         flagWrData,
  input logic [3:0]         flags
);
  // R5: a new H value comes with the H frequency flag
  p_hvalue_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hValue != $past(hValue)) |-> flags[1]);
  // R5: a new V value comes with the V frequency flag
  p_vvalue_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vValue != $past(vValue)) |-> flags[0]);
  // R5: H overflow onset sets the H frequency flag one cycle later
  p_hovf_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hOvf) |=> flags[1]);
  // R7: a change of H polarity comes with its flag
  p_hpol_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hPolPos != $past(hPolPos)) |-> flags[3]);
  // R9: without a write no flag falls
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !flagWrEn |=> ((flags & $past(flags)) == $past(flags)));
  // R9: writing 1 keeps a set flag
  p_keep_ones_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> (($past(flags & flagWrData) & ~flags) == 4'b0));
endmodule

bind sync_monitor sync_monitor_chk #(.H_OUT_W(H_OUT_W), .V_OUT_W(V_OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .hValue(hValue), .vValue(vValue), .hOvf(hOvf),
  .hPolPos(hPolPos), .flagWrEn(flagWrEn), .flagWrData(flagWrData), .flags(flags)
);

// File: tb/sync_monitor_tb_top.sv
`timescale 1ns/1ps
module sync_monitor_tb_top;
  localparam int HCW = 8, HOW = 5, HDV = 2, HLL = 2;
  localparam int VCW = 10, VOW = 6, VDV = 2, PLW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hSyncIn = 1'b0, vSyncIn = 1'b0;
  logic flagWrEn = 1'b0;
  logic [3:0] flagWrData = 4'hF, intEn = 4'h0;
  logic [HOW-1:0] hValue;
  logic [VOW-1:0] vValue;
  logic hOvf, vOvf, hPolPos, vPolPos, intN;
  logic [3:0] flags;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int hPer = 12, hHi = 3, vPer = 400, vHi = 20, hPh = 0, vPh = 0;
  bit hEn = 1'b0, vEn = 1'b0, glitch = 1'b0;

  always #10 clk = ~clk;

  sync_monitor #(
    .H_CNT_W(HCW), .H_OUT_W(HOW), .H_DIV(HDV), .H_LINES_LOG2(HLL),
    .V_CNT_W(VCW), .V_OUT_W(VOW), .V_DIV(VDV), .POL_W(PLW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .intEn(intEn),
    .hValue(hValue), .vValue(vValue), .hOvf(hOvf), .vOvf(vOvf),
    .hPolPos(hPolPos), .vPolPos(vPolPos), .flags(flags), .intN(intN)
  );

  // behavioural sync pattern source, driven away from the active edge
  always @(negedge clk) begin
    if (hEn) begin
      hSyncIn <= (hPh < hHi) || (glitch && hPh == 8);
      hPh = (hPh + 1 >= hPer) ? 0 : hPh + 1;
    end else begin
      hSyncIn <= 1'b0;
      hPh = 0;
    end
    if (vEn) begin
      vSyncIn <= (vPh < vHi);
      vPh = (vPh + 1 >= vPer) ? 0 : vPh + 1;
    end else begin
      vSyncIn <= 1'b0;
      vPh = 0;
    end
  end

  function automatic int expH(int per);
    return ((per * (1 << HLL)) / HDV) >> (HCW - HOW);
  endfunction
  function automatic int expV(int per);
    return (per / VDV) >> (VCW - VOW);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitVRise();
    do begin
      @(negedge clk);
      #1;
    end while (vPh != 1);
  endtask

  task automatic wrFlags(logic [3:0] d);
    @(negedge clk);
    flagWrEn = 1'b1;
    flagWrData = d;
    @(negedge clk);
    flagWrEn = 1'b0;
    flagWrData = 4'hF;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(5);
    // R11 reset state
    chk("R11 hValue", hValue, 0);
    chk("R11 vValue", vValue, 0);
    chk("R11 ovf", {hOvf, vOvf}, 0);
    chk("R11 polarity", {hPolPos, vPolPos}, 3);
    chk("R11 flags", flags, 0);
    chk("R11 intN", intN, 1);
    rstN = 1'b1;
    hEn = 1'b1; vEn = 1'b1;
    step(2000);
    chk("R1 hValue per12", hValue, expH(12));
    chk("R3 vValue per400", vValue, expV(400));
    chk("R6 positive pols", {hPolPos, vPolPos}, 3);
    chk("R4 no ovf", {hOvf, vOvf}, 0);
    chk("R5 freq flags after first values", flags, 4'b0011);
    wrFlags(4'b1111);
    chk("R9 write ones keeps", flags, 4'b0011);
    wrFlags(4'b0000);
    chk("R9 write zeros clears", flags, 4'b0000);
    intEn = 4'b0010;
    step(2);
    chk("R10 no flag no irq", intN, 1);

    // R2 latch once per frame while vsync runs
    waitVRise();
    hPer = 20;
    step(150);
    chk("R2 held until vsync", hValue, expH(12));
    chk("R5 no flag yet", flags[1], 0);
    waitVRise();
    step(20);
    chk("R2 update at vsync", hValue, expH(20));
    chk("R5 hFreq flag", flags[1], 1);
    chk("R10 irq asserted", intN, 0);
    intEn = 4'b0000;
    step(2);
    chk("R10 masked irq", intN, 1);
    wrFlags(4'b0000);

    // R6 / R7 polarity
    hHi = 15;
    step(100);
    chk("R6 long high is negative", hPolPos, 0);
    chk("R7 hPol flag", flags[3], 1);
    hHi = 10;
    step(100);
    chk("R6 equal is positive", hPolPos, 1);

    // R8 one-clock spike
    hPer = 12; hHi = 3;
    step(1000);
    wrFlags(4'b0000);
    glitch = 1'b1;
    step(1000);
    chk("R8 value with spikes", hValue, expH(12));
    chk("R8 polarity with spikes", hPolPos, 1);
    chk("R8 no flags", flags, 0);
    glitch = 1'b0;

    // R4 H overflow
    hEn = 1'b0;
    step(800);
    chk("R4 hOvf set", hOvf, 1);
    chk("R5 ovf sets hFreq", flags[1], 1);
    hEn = 1'b1;
    step(400);
    chk("R4 hOvf cleared", hOvf, 0);
    step(800);

    // R2 vsync absent: continuous update
    wrFlags(4'b0000);
    vEn = 1'b0;
    step(2600);
    chk("R4 vOvf set", vOvf, 1);
    chk("R5 ovf sets vFreq", flags[0], 1);
    hPer = 30; hHi = 5;
    step(400);
    chk("R2 continuous update", hValue, expH(30));
    chk("R3 vValue held", vValue, expV(400));
    vEn = 1'b1; vPer = 300;
    step(2000);
    chk("R4 vOvf cleared", vOvf, 0);
    chk("R3 vValue per300", vValue, expV(300));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule